// File: doc/BRIEF.md
# Skewed Counter Word Decoder

A fast pulse counter built from a chain of single-flop toggle stages keeps its logic between registers down to one gate. It does this by passing each carry to the next stage as a one-clock pulse, so bit k of the sampled state lags the input by a number of clocks that grows with k. A snapshot of such a counter is therefore not a plain binary number. This block takes that raw state word and rebuilds the true count, modulo 2^N.

The rebuild is a series of corrections, one per bit position from 1 to N-1, taken in increasing order. At position k the low k bits of the word, as already corrected by the steps before it, are compared against k. When they are smaller, a carry into bit k is still in flight, so bit k is inverted. Each correction sits in its own register stage. The decoder can therefore run at the counter's clock rate, take a new sample on every clock, and return each result N-1 clocks later together with a valid strobe that travels through the pipeline with the data.

Top module: `skew_count_decoder`

## Requirements
- R1: Corrections are applied to bit positions 1, 2, ... N-1 in that order. A step leaves every bit above its own position unchanged.
- R2: At step k, bit k is inverted exactly when the low k bits of the working word, read as an unsigned number, are less than k. Otherwise bit k is passed on unchanged.
- R3: Every step works on the word produced by the previous step. A step never alters the bits below its own position, so bit 0 of the result always equals bit 0 of the raw word.
- R4: For every N-bit raw word that the skewed counter can present after c counted pulses, the result equals c modulo 2^N. This includes the wrap from 2^N-1 to 0.
- R5: A sample presented with `raw_valid` high appears on `cnt_word`, with `cnt_valid` high, exactly N-1 rising clock edges later. `cnt_valid` is a copy of `raw_valid` delayed by N-1 edges.
- R6: A new sample may be presented on every clock. Back-to-back samples produce back-to-back results in the same order.
- R7: When `raw_valid` is low, the sample is ignored. While `cnt_valid` is low, `cnt_word` keeps the last decoded result.
- R8: While `rst_n` is low, and until the first valid result, `cnt_valid` is 0 and `cnt_word` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_valid | input | 1 | Qualifies `raw_word` in this cycle |
| raw_word | input | N | Skewed state word sampled from the counter |
| cnt_valid | output | 1 | Qualifies `cnt_word` |
| cnt_word | output | N | Linear count, modulo 2^N |

## Verification
Every decoded word is due exactly N-1 rising edges after its sample is taken, and `cnt_valid` follows `raw_valid` with the same delay. The bench keeps an expected pipe of that depth, filled with the true pulse count each time a sample is driven. At every falling edge it compares `cnt_valid` and `cnt_word` against the tail of that pipe. When the tail is empty, it instead checks that `cnt_word` still holds the previous result. Inside the stages, one-edge properties tie each register to the word it was given on the edge before.

// File: rtl/skdec_pkg.sv
package skdec_pkg;

  // Widest word the helper functions handle.
  localparam int unsigned MAX_W = 32;

  // Mask that keeps the low k bits of a word.
  function automatic logic [MAX_W-1:0] low_mask(input int unsigned k);
    if (k >= MAX_W) return '1;
    return (32'd1 << k) - 32'd1;
  endfunction

  // True when the low k bits are below k: a carry into bit k is still on its way.
  function automatic logic carry_in_flight(input logic [MAX_W-1:0] word,
                                           input int unsigned k);
    return (word & low_mask(k)) < k;
  endfunction

endpackage

// File: rtl/skdec_fix.sv
module skdec_fix #(
  parameter int W = 8,
  parameter int K = 1
) (
  input  logic [W-1:0] word_i,
  output logic         flip_o,
  output logic [W-1:0] word_o
);

  logic [skdec_pkg::MAX_W-1:0] word_ext;

  assign word_ext = skdec_pkg::MAX_W'(word_i);
  assign flip_o   = skdec_pkg::carry_in_flight(word_ext, K);

  always_comb begin
    word_o    = word_i;
    word_o[K] = word_i[K] ^ flip_o;
  end

endmodule

// File: rtl/skdec_stage.sv
module skdec_stage #(
  parameter int W = 8,
  parameter int K = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  output logic [W-1:0] out_word
);

  logic         flip_k;
  logic [W-1:0] fixed_word;
  logic         valid_q;
  logic [W-1:0] word_q;

  skdec_fix #(.W(W), .K(K)) u_fix (
    .word_i (in_word),
    .flip_o (flip_k),
    .word_o (fixed_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) word_q <= fixed_word;
    end
  end

  assign out_valid = valid_q;
  assign out_word  = word_q;

  // R5: the strobe moves one stage per edge
  a_r5_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R3: bits below this position are passed through as received
  a_r3_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_word[K-1:0] == $past(in_word[K-1:0]));

  // R2: bit K changes exactly when the comparator asked for it
  a_r2_flip_applied: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word[K] != $past(in_word[K])) == $past(flip_k));

  // R7: an empty slot leaves the held word untouched
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));

  generate
    if (K < W - 1) begin : g_upper
      // R1: later positions are not touched by this step
      a_r1_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[W-1:K+1] == $past(in_word[W-1:K+1]));
    end
  endgenerate

endmodule

// File: rtl/skew_count_decoder.sv
module skew_count_decoder #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         raw_valid,
  input  logic [N-1:0] raw_word,
  output logic         cnt_valid,
  output logic [N-1:0] cnt_word
);

  localparam int STAGES = N - 1;

  logic [N-1:0] word_c  [N];
  logic         valid_c [N];

  assign word_c[0]  = raw_word;
  assign valid_c[0] = raw_valid;

  generate
    for (genvar i = 1; i <= STAGES; i++) begin : g_step
      skdec_stage #(.W(N), .K(i)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (valid_c[i-1]),
        .in_word   (word_c[i-1]),
        .out_valid (valid_c[i]),
        .out_word  (word_c[i])
      );
    end
  endgenerate

  assign cnt_valid = valid_c[STAGES];
  assign cnt_word  = word_c[STAGES];

  // R8: nothing is announced while the pipe is under reset
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !cnt_valid);

  // R3: bit 0 of a result is bit 0 of the sample it came from
  a_r3_bit0_kept: assert property (@(posedge clk) disable iff (!rst_n)
    valid_c[STAGES-1] |=> cnt_word[0] == $past(word_c[STAGES-1][0]));

endmodule

// File: tb/skew_count_decoder_test.sv
`timescale 1ns/1ps
module skew_count_decoder_test;

  localparam int N     = 8;
  localparam int DEPTH = N - 1;
  localparam int MODV  = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         raw_valid = 1'b0;
  logic [N-1:0] raw_word = '0;
  logic         cnt_valid;
  logic [N-1:0] cnt_word;

  int compared = 0;
  int mismatched = 0;
  int count = 0;
  int drv_count = 0;
  logic [N-1:0] last_out = '0;

  logic         pv [DEPTH];
  logic [N-1:0] pd [DEPTH];

  always #2.5 clk = ~clk;

  skew_count_decoder #(.N(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_valid (raw_valid),
    .raw_word  (raw_word),
    .cnt_valid (cnt_valid),
    .cnt_word  (cnt_word)
  );

  // Skew a true count into the word the counter shows: the rule undone, top position first.
  function automatic logic [N-1:0] skew_of(input int c);
    int w;
    w = c % MODV;
    for (int k = N - 1; k >= 1; k--) begin
      if ((w % (1 << k)) < k) w = w ^ (1 << k);
    end
    return N'(w);
  endfunction

  // Expected pipe: the true count rides along with the sample.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin pv[i] <= 1'b0; pd[i] <= '0; end
    end else begin
      pv[0] <= raw_valid;
      pd[0] <= N'(drv_count % MODV);
      for (int i = 1; i < DEPTH; i++) begin pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R8 valid in reset", int'(cnt_valid), 0);
      check("R8 word in reset", int'(cnt_word), 0);
    end else begin
      check("R5 R6 valid timing", int'(cnt_valid), int'(pv[DEPTH-1]));
      if (pv[DEPTH-1]) begin
        check("R4 R1 R2 decoded count", int'(cnt_word), int'(pd[DEPTH-1]));
        last_out = pd[DEPTH-1];
      end else begin
        check("R7 hold while idle", int'(cnt_word), int'(last_out));
      end
    end
  end

  // Drive one sample (or an empty slot) just after the falling edge.
  task automatic drive(input logic v, input int c);
    @(negedge clk);
    #1;
    raw_valid = v;
    drv_count = c;
    raw_word  = v ? skew_of(c) : N'($urandom);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    // R8: quiet after reset release, before any sample has come through
    repeat (3) drive(1'b0, 0);

    // R4 R6: every count in turn, back to back, twice through the wrap
    for (int c = 0; c < 2 * MODV + 9; c++) drive(1'b1, c);
    repeat (DEPTH + 2) drive(1'b0, 0);

    // R7: sparse samples with gaps; the garbage in empty slots must be ignored
    count = 37;
    for (int i = 0; i < 600; i++) begin
      count += $urandom_range(0, 4);
      drive(($urandom_range(0, 3) == 0), count);
    end

    // R4: random pulse bursts, mostly back to back
    for (int i = 0; i < 3000; i++) begin
      count += $urandom_range(0, 3);
      drive(($urandom_range(0, 9) != 0), count);
    end

    // R4: lingering around the wrap point
    count = MODV - 6;
    for (int i = 0; i < 40; i++) begin
      count += $urandom_range(0, 1);
      drive(1'b1, count);
    end
    repeat (DEPTH + 3) drive(1'b0, 0);
    summary();
  end

endmodule